// File: doc/BRIEF.md
# Strided Raw Copy Engine

This block copies a region of memory to another region without touching the data. It moves 16-byte beats. Each beat is read from the source through a simple request interface and passes through a small internal buffer. It is then written to the destination in the same order. The copy stops once the programmed total byte count has been written.

In strided mode, the source and the destination each have their own line width and trailing gap, both counted in 16-byte units. After a full line of beats, the address on that side jumps past the gap. This lets a sub-rectangle move between buffers of different pitch. Gap bytes are skipped and are not part of the total. In contiguous mode, both sides simply advance 16 bytes per beat.

Parameters that would make the engine hang are rejected. The engine completes at once with an error flag set. Software pulses `start` while the engine is idle, then waits for `done` or the `irq` pulse.

Top module: `stride_copy`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `irq`, `rd_valid` and `wr_valid` are all low.
- R2: A `start` pulse while idle with valid parameters latches all inputs. In the next cycle `busy` is high and `done` and `err` are low.
- R3: The number of beats read and written equals `size_bytes >> 4`. The low four bits of `size_bytes` are ignored.
- R4: With `gap_en` = 0, beat i is read from `src_base + 16*i` and written to `dst_base + 16*i`. The width and gap inputs have no effect in this mode.
- R5: With `gap_en` = 1, each side is handled separately with its own width W and gap G. On that side, beat i goes to base + 16*((i / W)*(W + G) + i mod W).
- R6: Gap bytes are not counted toward the total. The beat count is the same as R3 whatever the gap values are.
- R7: The written data equals the returned read data, beat for beat, in request order.
- R8: A start is invalid when `gap_en` = 0 and `size_bytes` < 16. It is also invalid when `gap_en` = 1 and `size_bytes` < 192 or either width is zero. An invalid start issues no requests. In the next cycle it sets `err` and `done` with a one-cycle `irq`, and `busy` stays low.
- R9: In the cycle after the last write handshake, `busy` is low, `done` is high and `irq` is high. `irq` is high for exactly one cycle per job.
- R10: A `start` pulse while `busy` is high is ignored. The running job keeps its addresses and beat count.
- R11: Read requests are issued only while the number of beats read but not yet written is below DEPTH. Reads never run more than DEPTH beats ahead of writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a copy (only acted on while idle) |
| gap_en | input | 1 | 1 = apply per-line width and gap, 0 = contiguous |
| src_base | input | AW | Source byte address (16-byte aligned) |
| dst_base | input | AW | Destination byte address (16-byte aligned) |
| size_bytes | input | SW | Total bytes to move |
| src_width | input | LW | Source line width in 16-byte units |
| src_gap | input | LW | Source gap after each line in 16-byte units |
| dst_width | input | LW | Destination line width in 16-byte units |
| dst_gap | input | LW | Destination gap after each line in 16-byte units |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | AW | Read byte address |
| rd_rvalid | input | 1 | Read data returned |
| rd_rdata | input | 128 | Read data beat |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | AW | Write byte address |
| wr_data | output | 128 | Write data beat |
| busy | output | 1 | Copy in progress |
| done | output | 1 | Last job finished (valid or rejected) |
| err | output | 1 | Last start was rejected |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that read data comes back only for requests already accepted, one beat per accepted read, in request order. They also assume `start` is pulsed for one cycle. The bench's memory model follows these rules: it queues every accepted read address and returns each queued beat at a random later cycle, oldest first. The random jobs use widths of 1 to 5, gaps of 0 to 4 and sizes inside the legal ranges. A few directed jobs probe the rejection thresholds.

// File: rtl/stride_copy.sv
module stride_copy #(
  parameter int AW    = 32,
  parameter int SW    = 24,
  parameter int LW    = 12,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          gap_en,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [SW-1:0] size_bytes,
  input  logic [LW-1:0] src_width,
  input  logic [LW-1:0] src_gap,
  input  logic [LW-1:0] dst_width,
  input  logic [LW-1:0] dst_gap,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_rvalid,
  input  logic [127:0]  rd_rdata,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [127:0]  wr_data,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          irq
);
  localparam int BW = SW - 4;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          gap_q;
  logic [LW-1:0] sw_q, sg_q, dw_q, dg_q, rd_col, wr_col;
  logic [BW-1:0] beats_q, rd_cnt, wr_cnt;
  logic [CW-1:0] count, fill;
  logic [PW-1:0] wp, rp;
  logic [127:0]  mem [DEPTH];

  wire params_ok = gap_en ? (size_bytes >= SW'(192) && src_width != '0 && dst_width != '0)
                          : (size_bytes >= SW'(16));
  wire go       = start && !busy;
  wire rd_fire  = rd_valid && rd_ready;
  wire wr_fire  = wr_valid && wr_ready;
  wire rd_wrap  = gap_q && (rd_col == sw_q - 1'b1);
  wire wr_wrap  = gap_q && (wr_col == dw_q - 1'b1);
  wire last_wr  = wr_fire && (wr_cnt == beats_q - 1'b1);

  assign rd_valid = busy && (rd_cnt != beats_q) && (count < CW'(DEPTH));
  assign wr_valid = (fill != '0);
  assign wr_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (rd_rvalid) mem[wp] <= rd_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; err <= 1'b0; irq <= 1'b0;
      gap_q <= 1'b0; sw_q <= '0; sg_q <= '0; dw_q <= '0; dg_q <= '0;
      beats_q <= '0; rd_cnt <= '0; wr_cnt <= '0; rd_col <= '0; wr_col <= '0;
      rd_addr <= '0; wr_addr <= '0; count <= '0; fill <= '0; wp <= '0; rp <= '0;
    end else begin
      irq <= 1'b0;
      if (go) begin
        if (params_ok) begin
          busy <= 1'b1; done <= 1'b0; err <= 1'b0;
          gap_q <= gap_en; sw_q <= src_width; sg_q <= src_gap;
          dw_q <= dst_width; dg_q <= dst_gap;
          beats_q <= size_bytes[SW-1:4];
          rd_cnt <= '0; wr_cnt <= '0; rd_col <= '0; wr_col <= '0;
          rd_addr <= src_base; wr_addr <= dst_base;
        end else begin
          done <= 1'b1; err <= 1'b1; irq <= 1'b1;
        end
      end
      if (rd_fire) begin
        rd_cnt  <= rd_cnt + 1'b1;
        rd_col  <= rd_wrap ? '0 : rd_col + 1'b1;
        rd_addr <= rd_addr + AW'(16) + (rd_wrap ? AW'({sg_q, 4'b0000}) : '0);
      end
      if (wr_fire) begin
        wr_cnt  <= wr_cnt + 1'b1;
        wr_col  <= wr_wrap ? '0 : wr_col + 1'b1;
        wr_addr <= wr_addr + AW'(16) + (wr_wrap ? AW'({dg_q, 4'b0000}) : '0);
        rp      <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
      if (rd_rvalid) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      count <= count + CW'(rd_fire) - CW'(wr_fire);
      fill  <= fill + CW'(rd_rvalid) - CW'(wr_fire);
      if (last_wr) begin
        busy <= 1'b0; done <= 1'b1; irq <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/stride_copy_chk.sv
module stride_copy_chk #(
  parameter int CW    = 3,
  parameter int DEPTH = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          irq,
  input logic          rd_valid,
  input logic          wr_valid,
  input logic [CW-1:0] outst,
  input logic [CW-1:0] buffered
);
  a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
  a_r9_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (done && !busy));
  a_r2_busy_excl_done: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !done);
  a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  a_r8_err_idle: assert property (@(posedge clk) disable iff (!rst_n) err |-> (!busy && done));
  a_r8_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!rd_valid && !wr_valid));
  a_r11_credit_bound: assert property (@(posedge clk) disable iff (!rst_n) outst <= CW'(DEPTH));
  a_r11_fill_le_outst: assert property (@(posedge clk) disable iff (!rst_n) buffered <= outst);
endmodule

bind stride_copy stride_copy_chk #(.CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
  .irq(irq), .rd_valid(rd_valid), .wr_valid(wr_valid), .outst(count), .buffered(fill)
);

// File: tb/tb_stride_copy.sv
`timescale 1ns/1ps
module tb_stride_copy;
  localparam int AW = 32, SW = 24, LW = 12, DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, gap_en = 0;
  logic [AW-1:0] src_base = 0, dst_base = 0;
  logic [SW-1:0] size_bytes = 0;
  logic [LW-1:0] src_width = 0, src_gap = 0, dst_width = 0, dst_gap = 0;
  logic rd_valid, rd_ready = 0, rd_rvalid = 0;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [127:0] rd_rdata = 0, wr_data;
  logic wr_valid, wr_ready = 0;
  logic busy, done, err, irq;

  always #2 clk = ~clk;

  stride_copy #(.AW(AW), .SW(SW), .LW(LW), .DEPTH(DEPTH)) dut (.*);

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [AW-1:0] rq_q[$];
  logic [AW-1:0] rd_log[64];
  logic [AW-1:0] wa_log[64];
  logic [127:0]  wd_log[64];
  int n_rd = 0, n_wr = 0, n_irq = 0, ahead_max = 0;

  function automatic logic [127:0] pat(logic [AW-1:0] a);
    return {a ^ 32'h1234_5678, ~a, a + 32'd1, {a[15:0], a[31:16]}};
  endfunction

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, int w, int g, bit en, int i);
    if (!en) return b + AW'(16 * i);
    return b + AW'(16 * ((i / w) * (w + g) + (i % w)));
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      rd_ready = ($urandom % 4) != 0;
      wr_ready = ($urandom % 4) != 0;
      if (rq_q.size() > 0 && ($urandom % 4) != 0) begin
        rd_rvalid = 1'b1;
        rd_rdata  = pat(rq_q.pop_front());
      end else begin
        rd_rvalid = 1'b0;
      end
      if (rd_valid && rd_ready) begin
        rq_q.push_back(rd_addr);
        if (n_rd < 64) rd_log[n_rd] = rd_addr;
        n_rd++;
      end
      if (wr_valid && wr_ready) begin
        if (n_wr < 64) begin wa_log[n_wr] = wr_addr; wd_log[n_wr] = wr_data; end
        n_wr++;
      end
      if (n_rd - n_wr > ahead_max) ahead_max = n_rd - n_wr;
      if (irq) n_irq++;
    end
  end

  task automatic run_job(bit en, logic [AW-1:0] sb, logic [AW-1:0] db, int sz,
                         int sw, int sg, int dw, int dg, bit inject);
    bit ok;
    int beats, cyc;
    ok = en ? (sz >= 192 && sw != 0 && dw != 0) : (sz >= 16);
    beats = sz >> 4;
    @(negedge clk);
    n_rd = 0; n_wr = 0; n_irq = 0; ahead_max = 0;
    gap_en = en; src_base = sb; dst_base = db; size_bytes = SW'(sz);
    src_width = LW'(sw); src_gap = LW'(sg); dst_width = LW'(dw); dst_gap = LW'(dg);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == ok, ok ? "R2" : "R8", "busy after start", busy, ok);
    chk(err == !ok && done == !ok, ok ? "R2" : "R8", "err/done after start", {err, done}, {!ok, !ok});
    cyc = 0;
    while (busy && cyc < 3000) begin
      if (inject && cyc == 3) begin
        start = 1; src_base = 32'hDEAD_0000; dst_base = 32'hBEEF_0000; size_bytes = 24'h400;
        gap_en = !en;
      end else begin
        start = 0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 0;
    chk(cyc < 3000, "R9", "job finished", cyc, 0);
    @(negedge clk);
    @(negedge clk);
    chk(done && !busy && (err == !ok), "R9", "final flags", {done, busy, err}, {1'b1, 1'b0, !ok});
    chk(n_irq == 1, "R9", "irq pulses", n_irq, 1);
    if (!ok) begin
      chk(n_rd == 0 && n_wr == 0, "R8", "requests on rejected job", n_rd + n_wr, 0);
    end else begin
      chk(n_rd == beats && n_wr == beats, inject ? "R10" : "R3", "beat counts", {n_rd, n_wr}, {beats, beats});
      chk(ahead_max <= DEPTH, "R11", "reads ahead of writes", ahead_max, DEPTH);
      for (int i = 0; i < beats && i < 64; i++) begin
        logic [AW-1:0] ea, eb;
        ea = exp_addr(sb, sw, sg, en, i);
        eb = exp_addr(db, dw, dg, en, i);
        chk(rd_log[i] == ea, en ? "R5" : "R4", "read address", rd_log[i], ea);
        chk(wa_log[i] == eb, en ? "R5" : "R4", "write address", wa_log[i], eb);
        chk(wd_log[i] == pat(ea), "R7", "write data", wd_log[i][31:0], pat(ea) & 32'hFFFFFFFF);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !irq && !rd_valid && !wr_valid, "R1", "reset outputs",
        {busy, done, err, irq, rd_valid, wr_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    // R4: contiguous, width/gap inputs ignored
    run_job(0, 32'h1000, 32'h8000, 64, 2, 7, 3, 5, 0);
    // R3: low bits of size ignored
    run_job(0, 32'h2000, 32'h9000, 'h47, 0, 0, 0, 0, 0);
    // R5 R6: separate strides, gaps not counted
    run_job(1, 32'h3000, 32'hA000, 192, 2, 3, 4, 1, 0);
    run_job(1, 32'h3400, 32'hA400, 208, 1, 0, 5, 0, 0);
    // R8: rejection thresholds
    run_job(0, 32'h0, 32'h0, 15, 1, 1, 1, 1, 0);
    run_job(1, 32'h0, 32'h0, 176, 2, 1, 2, 1, 0);
    run_job(1, 32'h0, 32'h0, 256, 0, 1, 2, 1, 0);
    run_job(1, 32'h0, 32'h0, 256, 2, 1, 0, 1, 0);
    run_job(0, 32'h4000, 32'hB000, 16, 0, 0, 0, 0, 0);
    // R10: start while busy ignored
    run_job(1, 32'h5000, 32'hC000, 320, 3, 2, 2, 4, 1);
    for (int k = 0; k < 10; k++) begin
      bit en;
      int sz;
      en = $urandom % 2;
      sz = en ? 192 + ($urandom % 449) : 16 + ($urandom % 625);
      run_job(en, 32'h10000 + 32'(k) * 32'h1000, 32'h80000 + 32'(k) * 32'h1000, sz,
              1 + $urandom % 5, $urandom % 5, 1 + $urandom % 5, $urandom % 5, 0);
    end
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule